// File: doc/BRIEF.md
# Register-Pair Operand Access Unit

This unit sits next to a 32-entry, 32-bit general register file in a 32-bit core. It lets double-precision and 64-bit integer operands live in pairs of ordinary registers. From a floating-point instruction word it forms three 6-bit pair selectors: destination D, source A and source B. Each selector holds a 5-bit first-register index and an offset flag. The flag picks the second register of the pair as either the next register or the one after it.

The unit has three combinational 64-bit pair read ports. A and B are the operands. D doubles as the accumulator input for multiply-add. It also has one 64-bit pair write port, which targets D and updates both registers on the same clock edge, and a plain 32-bit single-register read and write path.

The operation class comes in on `op_i`. The unit uses it to suppress the write for compares and to flag reserved instruction bits that are set. The arithmetic itself happens elsewhere; this block only routes operands.

Top module: `regpair_access_unit`

## Requirements
- R1: The D selector is {insn[10], insn[25:21]}, the A selector is {insn[9], insn[20:16]} and the B selector is {insn[8], insn[15:11]}. They appear on `sel_d_o`, `sel_a_o` and `sel_b_o`.
- R2: The second register of a pair is the first index plus 1 when the flag (selector bit 5) is 0, and plus 2 when it is 1, taken modulo 32. `pair_wrap_o` bit 0 (D), bit 1 (A) or bit 2 (B) is 1 exactly when that sum exceeds 31.
- R3: Each 64-bit read port returns {first register, second register}, with the first register in bits 63:32. The reads are combinational, and port D is readable together with A and B, which a multiply-add needs (op 1).
- R4: When `wr64_en_i` is high and the op is not a compare, the next rising edge stores bits 63:32 into the D first register and bits 31:0 into the D second register.
- R5: Register 0 always reads zero and ignores writes, on the 32-bit path and as either register of a pair.
- R6: With op 2 (compare), the 64-bit write is suppressed even when `wr64_en_i` is high.
- R7: `rsv_err_o` is 1 when op is 2 and insn[10] is 1, or when op is 3 (integer to double) or 4 (double to integer) and either insn[15:11] is nonzero or insn[8] is 1. It is 0 for every other op (0 = arithmetic, 1 = multiply-add).
- R8: A read of a register that is written in the same cycle returns the old value; the new value is visible after the edge.
- R9: The 32-bit path reads the register at `rd32_addr_i` combinationally and writes `wr32_data_i` on the edge when `wr32_en_i` is high. When the pair write hits the same register in the same cycle, the pair write wins.
- R10: An active-low asynchronous reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Floating-point instruction word |
| op_i | input | 3 | Operation class: 0 arith, 1 multiply-add, 2 compare, 3 int-to-double, 4 double-to-int |
| wr64_en_i | input | 1 | Pair write enable for D |
| wr64_data_i | input | 64 | Pair write data |
| wr32_en_i | input | 1 | Single-register write enable |
| wr32_addr_i | input | 5 | Single-register write index |
| wr32_data_i | input | 32 | Single-register write data |
| rd32_addr_i | input | 5 | Single-register read index |
| rd32_data_o | output | 32 | Single-register read data |
| rd_d64_o | output | 64 | D pair read (accumulator) |
| rd_a64_o | output | 64 | A pair read |
| rd_b64_o | output | 64 | B pair read |
| sel_d_o | output | 6 | D pair selector |
| sel_a_o | output | 6 | A pair selector |
| sel_b_o | output | 6 | B pair selector |
| pair_wrap_o | output | 3 | Second index wrapped past 31 (bit 0 D, 1 A, 2 B) |
| rsv_err_o | output | 1 | Reserved instruction bits set for this op |

## Verification
The write-visibility properties assume that the instruction word stays unchanged across the write edge. When it does change, they check nothing, since the D read port then looks at other registers. The compare-hold property also assumes no 32-bit write is active in that cycle.

The stimulus changes `insn_i` only on falling edges and holds it through each pair write and the following read-back. It uses the 32-bit path only to preload registers or, on purpose, in the collision scenario. Reset is applied once, before any traffic.

// File: rtl/rpu_pkg.sv
package rpu_pkg;

  typedef enum logic [2:0] {
    OP_ARITH = 3'd0,
    OP_MADD  = 3'd1,
    OP_CMP   = 3'd2,
    OP_ITOF  = 3'd3,
    OP_FTOI  = 3'd4
  } op_e;

  localparam int NPAIR  = 3;
  localparam int PAIR_D = 0;
  localparam int PAIR_A = 1;
  localparam int PAIR_B = 2;

  // index field lsb per pair port
  function automatic int idx_lsb(int p);
    case (p)
      PAIR_D:  return 21;
      PAIR_A:  return 16;
      default: return 11;
    endcase
  endfunction

  // offset-flag bit per pair port (decoded by the instruction format)
  function automatic int off_bit(int p);
    case (p)
      PAIR_D:  return 10;
      PAIR_A:  return 9;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/rpu_decode.sv
module rpu_decode
  import rpu_pkg::*;
#(
  parameter int IW   = 32,
  parameter int IDXW = 5
) (
  input  logic [IW-1:0]                 insn_i,
  input  op_e                           op_i,
  output logic [NPAIR-1:0][IDXW:0]      sel_o,
  output logic                          wr_ok_o,
  output logic                          rsv_err_o
);

  for (genvar p = 0; p < NPAIR; p++) begin : g_sel
    localparam int L = idx_lsb(p);
    localparam int F = off_bit(p);
    assign sel_o[p] = {insn_i[F], insn_i[L +: IDXW]};
  end

  localparam int BL = idx_lsb(PAIR_B);
  localparam int BF = off_bit(PAIR_B);
  localparam int DF = off_bit(PAIR_D);

  assign wr_ok_o = (op_i != OP_CMP);

  always_comb begin
    case (op_i)
      OP_CMP:          rsv_err_o = insn_i[DF];
      OP_ITOF, OP_FTOI: rsv_err_o = (|insn_i[BL +: IDXW]) | insn_i[BF];
      default:         rsv_err_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/rpu_pair_map.sv
module rpu_pair_map #(
  parameter int IDXW = 5
) (
  input  logic [IDXW:0]   sel_i,
  output logic [IDXW-1:0] first_o,
  output logic [IDXW-1:0] second_o,
  output logic            wrap_o
);

  logic [IDXW:0] sum;

  assign first_o  = sel_i[IDXW-1:0];
  assign sum      = {1'b0, sel_i[IDXW-1:0]} + (sel_i[IDXW] ? (IDXW+1)'(2) : (IDXW+1)'(1));
  assign second_o = sum[IDXW-1:0];
  assign wrap_o   = sum[IDXW];

endmodule

// File: rtl/rpu_regfile.sv
module rpu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 7,
  parameter int NWR  = 3,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NWR-1:0]                 we_i,
  input  logic [NWR-1:0][IDXW-1:0]       wa_i,
  input  logic [NWR-1:0][XLEN-1:0]       wd_i,
  input  logic [NRD-1:0][IDXW-1:0]       ra_i,
  output logic [NRD-1:0][XLEN-1:0]       rd_o
);

  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;

  // higher-numbered write port wins on collision
  for (genvar r = 1; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs[r] <= '0;
      end else begin
        for (int w = 0; w < NWR; w++) begin
          if (we_i[w] && (wa_i[w] == IDXW'(r))) regs[r] <= wd_i[w];
        end
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_o[p] = regs[ra_i[p]];
  end

endmodule

// File: rtl/regpair_access_unit.sv
module regpair_access_unit
  import rpu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int IW   = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IW-1:0]     insn_i,
  input  logic [2:0]        op_i,
  input  logic              wr64_en_i,
  input  logic [2*XLEN-1:0] wr64_data_i,
  input  logic              wr32_en_i,
  input  logic [IDXW-1:0]   wr32_addr_i,
  input  logic [XLEN-1:0]   wr32_data_i,
  input  logic [IDXW-1:0]   rd32_addr_i,
  output logic [XLEN-1:0]   rd32_data_o,
  output logic [2*XLEN-1:0] rd_d64_o,
  output logic [2*XLEN-1:0] rd_a64_o,
  output logic [2*XLEN-1:0] rd_b64_o,
  output logic [IDXW:0]     sel_d_o,
  output logic [IDXW:0]     sel_a_o,
  output logic [IDXW:0]     sel_b_o,
  output logic [NPAIR-1:0]  pair_wrap_o,
  output logic              rsv_err_o
);

  localparam int NRD = 1 + 2*NPAIR;
  localparam int NWR = 3;

  logic [NPAIR-1:0][IDXW:0]   sel;
  logic [NPAIR-1:0][IDXW-1:0] first_idx;
  logic [NPAIR-1:0][IDXW-1:0] second_idx;
  logic [NPAIR-1:0][2*XLEN-1:0] pair_rd;
  logic                       wr_ok;

  logic [NWR-1:0]             we;
  logic [NWR-1:0][IDXW-1:0]   wa;
  logic [NWR-1:0][XLEN-1:0]   wd;
  logic [NRD-1:0][IDXW-1:0]   ra;
  logic [NRD-1:0][XLEN-1:0]   rd;

  rpu_decode #(.IW(IW), .IDXW(IDXW)) u_decode (
    .insn_i    (insn_i),
    .op_i      (op_e'(op_i)),
    .sel_o     (sel),
    .wr_ok_o   (wr_ok),
    .rsv_err_o (rsv_err_o)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    rpu_pair_map #(.IDXW(IDXW)) u_map (
      .sel_i    (sel[p]),
      .first_o  (first_idx[p]),
      .second_o (second_idx[p]),
      .wrap_o   (pair_wrap_o[p])
    );
    assign ra[1 + 2*p] = first_idx[p];
    assign ra[2 + 2*p] = second_idx[p];
    assign pair_rd[p]  = {rd[1 + 2*p], rd[2 + 2*p]};
  end

  assign ra[0] = rd32_addr_i;

  // port 0: single write; ports 1/2: pair halves (override port 0)
  assign we[0] = wr32_en_i;
  assign wa[0] = wr32_addr_i;
  assign wd[0] = wr32_data_i;
  assign we[1] = wr64_en_i & wr_ok;
  assign wa[1] = first_idx[PAIR_D];
  assign wd[1] = wr64_data_i[2*XLEN-1:XLEN];
  assign we[2] = wr64_en_i & wr_ok;
  assign wa[2] = second_idx[PAIR_D];
  assign wd[2] = wr64_data_i[XLEN-1:0];

  rpu_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD), .NWR(NWR)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .wa_i   (wa),
    .wd_i   (wd),
    .ra_i   (ra),
    .rd_o   (rd)
  );

  assign rd32_data_o = rd[0];
  assign rd_d64_o    = pair_rd[PAIR_D];
  assign rd_a64_o    = pair_rd[PAIR_A];
  assign rd_b64_o    = pair_rd[PAIR_B];
  assign sel_d_o     = sel[PAIR_D];
  assign sel_a_o     = sel[PAIR_A];
  assign sel_b_o     = sel[PAIR_B];

endmodule

// File: rtl/rpu_checker.sv
module rpu_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] insn_i,
  input logic [2:0]  op_i,
  input logic        wr64_en_i,
  input logic [63:0] wr64_data_i,
  input logic        wr32_en_i,
  input logic [4:0]  rd32_addr_i,
  input logic [31:0] rd32_data_o,
  input logic [63:0] rd_d64_o,
  input logic [2:0]  pair_wrap_o,
  input logic        rsv_err_o
);

  logic [4:0] d_first;
  logic [4:0] d_second;
  logic       pair_wr;

  assign d_first  = insn_i[25:21];
  assign d_second = d_first + (insn_i[10] ? 5'd2 : 5'd1);
  assign pair_wr  = wr64_en_i && (op_i != 3'd2);

  p_hi_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_wr && d_first != 5'd0) |=>
      (!$stable(insn_i) || rd_d64_o[63:32] == $past(wr64_data_i[63:32])));

  p_lo_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_wr && d_second != 5'd0) |=>
      (!$stable(insn_i) || rd_d64_o[31:0] == $past(wr64_data_i[31:0])));

  p_cmp_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && !wr32_en_i) |=> (!$stable(insn_i) || $stable(rd_d64_o)));

  p_zero_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd32_addr_i == 5'd0) |-> (rd32_data_o == 32'd0));

  p_wrap_d_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_wrap_o[0] |-> (insn_i[25:21] >= 5'd30));

  p_rsv_cmp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && insn_i[10]) |-> rsv_err_o);

endmodule

bind regpair_access_unit rpu_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .insn_i      (insn_i),
  .op_i        (op_i),
  .wr64_en_i   (wr64_en_i),
  .wr64_data_i (wr64_data_i),
  .wr32_en_i   (wr32_en_i),
  .rd32_addr_i (rd32_addr_i),
  .rd32_data_o (rd32_data_o),
  .rd_d64_o    (rd_d64_o),
  .pair_wrap_o (pair_wrap_o),
  .rsv_err_o   (rsv_err_o)
);

// File: tb/regpair_access_unit_tb.sv
module regpair_access_unit_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic [2:0]  op = 3'd0;
  logic        wr64_en = 1'b0;
  logic [63:0] wr64_data = '0;
  logic        wr32_en = 1'b0;
  logic [4:0]  wr32_addr = '0;
  logic [31:0] wr32_data = '0;
  logic [4:0]  rd32_addr = '0;
  logic [31:0] rd32_data;
  logic [63:0] rd_d64, rd_a64, rd_b64;
  logic [5:0]  sel_d, sel_a, sel_b;
  logic [2:0]  pair_wrap;
  logic        rsv_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m [32];

  always #2.5 clk = ~clk;

  regpair_access_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .insn_i(insn), .op_i(op),
    .wr64_en_i(wr64_en), .wr64_data_i(wr64_data),
    .wr32_en_i(wr32_en), .wr32_addr_i(wr32_addr), .wr32_data_i(wr32_data),
    .rd32_addr_i(rd32_addr), .rd32_data_o(rd32_data),
    .rd_d64_o(rd_d64), .rd_a64_o(rd_a64), .rd_b64_o(rd_b64),
    .sel_d_o(sel_d), .sel_a_o(sel_a), .sel_b_o(sel_b),
    .pair_wrap_o(pair_wrap), .rsv_err_o(rsv_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int di, int df, int ai, int af, int bi, int bf);
    logic [31:0] x = '0;
    x[25:21] = di[4:0]; x[10] = df[0];
    x[20:16] = ai[4:0]; x[9]  = af[0];
    x[15:11] = bi[4:0]; x[8]  = bf[0];
    return x;
  endfunction

  function automatic int sec(int i, int f);
    return (i + (f != 0 ? 2 : 1)) % 32;
  endfunction

  function automatic logic [31:0] rv(int i);
    return (i == 0) ? 32'd0 : m[i];
  endfunction

  function automatic logic [63:0] pexp(int i, int f);
    return {rv(i), rv(sec(i, f))};
  endfunction

  task automatic w32(int i, logic [31:0] d);
    @(negedge clk);
    wr32_en = 1'b1; wr32_addr = i[4:0]; wr32_data = d;
    @(negedge clk);
    wr32_en = 1'b0;
    if (i != 0) m[i] = d;
  endtask

  task automatic w64(int di, int df, logic [2:0] o, logic [63:0] d);
    @(negedge clk);
    insn = mk(di, df, 0, 0, 0, 0); op = o; wr64_en = 1'b1; wr64_data = d;
    @(negedge clk);
    wr64_en = 1'b0;
    if (o != 3'd2) begin
      if (di != 0) m[di] = d[63:32];
      if (sec(di, df) != 0) m[sec(di, df)] = d[31:0];
    end
  endtask

  task automatic rd32_chk(string tag, int i);
    rd32_addr = i[4:0];
    #1;
    chk(tag, {32'd0, rd32_data}, {32'd0, rv(i)});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 32; i++) m[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) rd32_chk("R10 reset clear", i);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 32; i++) w32(i, 32'hA500_0000 | (i * 32'h0001_0111));
    for (int i = 1; i < 32; i += 5) rd32_chk("R9 single write/read", i);
  endtask

  task automatic t_decode;
    @(negedge clk);
    insn = mk(5, 1, 17, 0, 30, 1); op = 3'd0;
    #1;
    chk("R1 sel D", {58'd0, sel_d}, {58'd0, 6'b1_00101});
    chk("R1 sel A", {58'd0, sel_a}, {58'd0, 6'b0_10001});
    chk("R1 sel B", {58'd0, sel_b}, {58'd0, 6'b1_11110});
  endtask

  task automatic t_read(int di, int df, int ai, int af, int bi, int bf);
    @(negedge clk);
    insn = mk(di, df, ai, af, bi, bf); op = 3'd1;
    #1;
    chk("R3 read D", rd_d64, pexp(di, df));
    chk("R3 read A", rd_a64, pexp(ai, af));
    chk("R3 read B", rd_b64, pexp(bi, bf));
  endtask

  task automatic t_wrap;
    @(negedge clk);
    insn = mk(31, 1, 31, 0, 30, 1); op = 3'd0;
    #1;
    chk("R2 wrap flags", {61'd0, pair_wrap}, {61'd0, 3'b111});
    chk("R2 A wraps to r0", rd_a64, {m[31], 32'd0});
    chk("R2 B wraps to r0", rd_b64, {m[30], 32'd0});
    chk("R2 D wraps to r1", rd_d64, {m[31], m[1]});
    @(negedge clk);
    insn = mk(29, 0, 29, 1, 28, 1);
    #1;
    chk("R2 no wrap", {61'd0, pair_wrap}, {61'd0, 3'b000});
    chk("R2 stride 2 to r31", rd_a64, {m[29], m[31]});
  endtask

  task automatic t_write;
    w64(16, 1, 3'd0, 64'h1111_2222_3333_4444);
    rd32_chk("R4 hi to first", 16);
    rd32_chk("R4 lo to second (stride 2)", 18);
    chk("R4 skipped reg untouched", {32'd0, m[17]}, {32'd0, 32'hA500_0000 | (17 * 32'h0001_0111)});
    rd32_chk("R4 skipped reg read", 17);
    w64(3, 0, 3'd1, 64'hDEAD_BEEF_CAFE_F00D);
    rd32_chk("R4 hi stride 1", 3);
    rd32_chk("R4 lo stride 1", 4);
  endtask

  task automatic t_reg0;
    w32(0, 32'hFFFF_FFFF);
    rd32_chk("R5 r0 ignores single write", 0);
    w64(31, 0, 3'd0, 64'h7777_8888_9999_AAAA);
    rd32_chk("R5 r0 as second of pair", 0);
    rd32_chk("R5 first of wrapping pair", 31);
    w64(0, 1, 3'd0, 64'h1234_5678_9ABC_DEF0);
    rd32_chk("R5 r0 as first of pair", 0);
    rd32_chk("R5 second after r0", 2);
  endtask

  task automatic t_cmp;
    logic [31:0] o7 = m[7];
    logic [31:0] o8 = m[8];
    w64(7, 0, 3'd2, 64'h0BAD_0BAD_0BAD_0BAD);
    rd32_addr = 5'd7; #1;
    chk("R6 compare no write first", {32'd0, rd32_data}, {32'd0, o7});
    rd32_addr = 5'd8; #1;
    chk("R6 compare no write second", {32'd0, rd32_data}, {32'd0, o8});
  endtask

  task automatic t_rsv;
    @(negedge clk);
    insn = mk(1, 1, 2, 0, 3, 0); op = 3'd2; #1;
    chk("R7 cmp bit10 set", {63'd0, rsv_err}, 64'd1);
    insn = mk(1, 0, 2, 1, 3, 1); #1;
    chk("R7 cmp bit10 clear", {63'd0, rsv_err}, 64'd0);
    insn = mk(4, 0, 6, 0, 9, 0); op = 3'd3; #1;
    chk("R7 itof b field nonzero", {63'd0, rsv_err}, 64'd1);
    insn = mk(4, 1, 6, 1, 0, 1); op = 3'd4; #1;
    chk("R7 ftoi bit8 set", {63'd0, rsv_err}, 64'd1);
    insn = mk(4, 1, 6, 1, 0, 0); op = 3'd3; #1;
    chk("R7 itof clean", {63'd0, rsv_err}, 64'd0);
    insn = mk(4, 1, 6, 1, 31, 1); op = 3'd0; #1;
    chk("R7 arith never flags", {63'd0, rsv_err}, 64'd0);
  endtask

  task automatic t_rdw;
    logic [63:0] old;
    @(negedge clk);
    insn = mk(10, 0, 10, 0, 0, 0); op = 3'd0;
    wr64_en = 1'b1; wr64_data = 64'hFACE_0001_FACE_0002;
    #1;
    old = pexp(10, 0);
    chk("R8 old value during write", rd_d64, old);
    chk("R8 old value on A port", rd_a64, old);
    @(negedge clk);
    wr64_en = 1'b0;
    m[10] = 32'hFACE_0001; m[11] = 32'hFACE_0002;
    #1;
    chk("R8 new value after edge", rd_d64, pexp(10, 0));
  endtask

  task automatic t_prio;
    @(negedge clk);
    insn = mk(12, 0, 0, 0, 0, 0); op = 3'd0;
    wr64_en = 1'b1; wr64_data = 64'h6464_6464_3232_3232;
    wr32_en = 1'b1; wr32_addr = 5'd12; wr32_data = 32'h0000_0032;
    @(negedge clk);
    wr64_en = 1'b0; wr32_en = 1'b0;
    m[12] = 32'h6464_6464; m[13] = 32'h3232_3232;
    rd32_chk("R9 pair write wins", 12);
  endtask

  bit done = 0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_fill;
    t_decode;
    t_read(2, 0, 5, 1, 20, 0);
    t_read(15, 1, 1, 0, 27, 1);
    t_read(8, 1, 8, 0, 8, 1);
    t_wrap;
    t_write;
    t_reg0;
    t_cmp;
    t_rsv;
    t_rdw;
    t_prio;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule